// File: doc/BRIEF.md
# Precision-Reconfigurable Packed Multiplier Element

This processing element multiplies quantized operands whose bit width is chosen at run time. It takes an 8-bit weight lane and an 8-bit activation lane. A pair of 2-bit selects gives the operand widths, one for the weight and one for the activation. When both widths are 8 bits, the lanes hold one operand pair and the element forms one product. With narrower widths, each lane is cut into equal slots and every slot is multiplied on its own. Because the channels run in parallel, a 2-bit setting yields four products per cycle from the same shift-add hardware.

The product of each weight bit with the activation is one bit-level partial product. The active width regroups these partial products into shifted sums, one sum per channel. A signed select treats operands as two's complement: the activation is sign-extended, and the partial product of the weight's top bit is subtracted. Each channel result goes to its own 16-bit output slot.

The element has one register stage. The selects are captured together with the data, so the precision may change on every valid cycle with no stall. Accumulation across cycles and the array dataflow belong to the surrounding logic.

Top module: `prmul_pe`

## Requirements
- R1: The precision select encoding is 00 = 1 bit, 01 = 2 bits, 10 = 4 bits and 11 = 8 bits, and weights and activations use the same encoding. The slot width P is the larger of the two widths, and there are 8/P channels. Channel k reads lane bits [k*P +: P], and each operand sits in the low bits of its slot.
- R2: In unsigned mode (is_signed = 0), channel k's product is zero-extended into prod[16k+15:16k].
- R3: In signed mode (is_signed = 1), an operand wider than 1 bit is two's complement at its own width. The product is sign-extended to 16 bits, so an 8x8 product of -128 by -128 gives 16384.
- R4: A 1-bit operand is always read as unsigned 0 or 1, so a 1-bit by 1-bit channel gives the logical AND of the two bits.
- R5: Output slots whose index is 8/P or higher are zero.
- R6: The weight width and the activation width are set independently. For example, a 4-bit weight with an 8-bit activation gives one channel whose weight is lane bits [3:0].
- R7: An input with in_valid = 1 at a rising edge appears on prod, with out_valid = 1, after that same edge. The selects in force are the ones captured with that input, and different precisions on back-to-back cycles cause no stall.
- R8: A cycle with in_valid = 0 leaves prod unchanged and drives out_valid to 0.
- R9: While rst_n = 0, out_valid and prod are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input lanes and selects are valid |
| w_prec | input | 2 | Weight width select |
| a_prec | input | 2 | Activation width select |
| is_signed | input | 1 | Two's-complement operands |
| w_lane | input | 8 | Packed weight lane |
| a_lane | input | 8 | Packed activation lane |
| out_valid | output | 1 | Products are valid |
| prod | output | 128 | Eight 16-bit product slots |

## Verification
The assertions check on every cycle that the valid handshake has exactly one cycle of latency and that prod stays put when no data arrives. They also check that the upper slots are zero in 8-bit operation, that unsigned narrow products never set the upper byte of slot 0, and that a 1-bit by 1-bit channel 0 equals the AND of its bits. The numeric values of the products in every mix of widths, sign handling at the extreme codes, and precision changes on back-to-back cycles can only be shown by the bench's scenarios, which compare against an integer model.

// File: rtl/prmul_pe.sv
module prmul_pe #(
  parameter int LANE_W = 8,
  parameter int SLOT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [1:0]               w_prec,
  input  logic [1:0]               a_prec,
  input  logic                     is_signed,
  input  logic [LANE_W-1:0]        w_lane,
  input  logic [LANE_W-1:0]        a_lane,
  output logic                     out_valid,
  output logic [LANE_W*SLOT_W-1:0] prod
);
  localparam int NSLOT = LANE_W;
  localparam int OUT_W = NSLOT * SLOT_W;

  logic [OUT_W-1:0] nxt;

  always_comb begin
    int wb, ab, pb;
    logic [LANE_W-1:0] wseg, aseg;
    logic [SLOT_W-1:0] a_ext, acc, pp;
    logic a_neg;
    wb = 1 << w_prec;
    ab = 1 << a_prec;
    pb = (wb > ab) ? wb : ab;
    nxt = '0;
    for (int k = 0; k < NSLOT; k++) begin
      wseg  = w_lane >> (k * pb);
      aseg  = a_lane >> (k * pb);
      a_neg = is_signed && ab > 1 && ((aseg >> (ab - 1)) & {{(LANE_W-1){1'b0}}, 1'b1}) != '0;
      for (int j = 0; j < SLOT_W; j++)
        a_ext[j] = (j < ab && j < LANE_W) ? aseg[j % LANE_W] : a_neg;
      acc = '0;
      for (int i = 0; i < LANE_W; i++) begin
        pp = a_ext << i;
        if (i < wb && wseg[i]) begin
          if (is_signed && wb > 1 && i == wb - 1) acc = acc - pp;
          else acc = acc + pp;
        end
      end
      if (k * pb < LANE_W) nxt[k*SLOT_W +: SLOT_W] = acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      prod      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) prod <= nxt;
    end
  end

  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(prod)));

  a_r5_full_width_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (w_prec == 2'b11 || a_prec == 2'b11) |=> prod[OUT_W-1:SLOT_W] == '0);

  a_r2_unsigned_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !is_signed && w_prec != 2'b11 && a_prec != 2'b11
      |=> prod[SLOT_W-1:LANE_W] == '0);

  a_r4_and_bit: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && w_prec == 2'b00 && a_prec == 2'b00
      |=> prod[SLOT_W-1:0] == {{(SLOT_W-1){1'b0}}, $past(w_lane[0] & a_lane[0])});
endmodule

// File: tb/sim_prmul_pe.sv
module sim_prmul_pe;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, is_signed = 1'b0;
  logic [1:0] w_prec = '0, a_prec = '0;
  logic [7:0] w_lane = '0, a_lane = '0;
  logic out_valid;
  logic [127:0] prod;
  int n_cmp = 0, n_bad = 0;
  logic [127:0] exp_prod = '0;
  bit done = 0;

  always #5 clk = ~clk;

  prmul_pe u0 (.clk, .rst_n, .in_valid, .w_prec, .a_prec, .is_signed,
               .w_lane, .a_lane, .out_valid, .prod);

  function automatic logic [127:0] model(logic [7:0] w, logic [7:0] a,
                                         logic [1:0] wp, logic [1:0] ap, logic s);
    logic [127:0] r = '0;
    int wb = 1 << wp, ab = 1 << ap;
    int p = (wb > ab) ? wb : ab;
    for (int k = 0; k < 8 / p; k++) begin
      int wv = (int'(w) >> (k * p)) & ((1 << wb) - 1);
      int av = (int'(a) >> (k * p)) & ((1 << ab) - 1);
      int pr;
      if (s && wb > 1 && wv >= (1 << (wb - 1))) wv -= (1 << wb);
      if (s && ab > 1 && av >= (1 << (ab - 1))) av -= (1 << ab);
      pr = wv * av;
      r[k*16 +: 16] = pr[15:0];
    end
    return r;
  endfunction

  task automatic check(string tag, logic ev);
    n_cmp++;
    if (out_valid !== ev || prod !== exp_prod) begin
      n_bad++;
      $display("FAIL %s: out_valid=%0b prod=%h expected out_valid=%0b prod=%h",
               tag, out_valid, prod, ev, exp_prod);
    end
  endtask

  task automatic step(string tag, logic v, logic [7:0] w, logic [7:0] a,
                      logic [1:0] wp, logic [1:0] ap, logic s);
    in_valid = v; w_lane = w; a_lane = a; w_prec = wp; a_prec = ap; is_signed = s;
    if (v) exp_prod = model(w, a, wp, ap, s);
    @(negedge clk);
    check(tag, v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    step("R3 -128*-128", 1, 8'h80, 8'h80, 2'b11, 2'b11, 1);
    if (prod[15:0] !== 16'd16384) begin
      n_bad++; $display("FAIL R3: slot0=%0d expected 16384", prod[15:0]);
    end
    n_cmp++;
    step("R3 -128*127", 1, 8'h80, 8'h7f, 2'b11, 2'b11, 1);
    step("R2 255*255", 1, 8'hff, 8'hff, 2'b11, 2'b11, 0);
    step("R4 and ones", 1, 8'hff, 8'hff, 2'b00, 2'b00, 1);
    step("R4 and mix", 1, 8'hb5, 8'h6c, 2'b00, 2'b00, 0);
    step("R1 2bit signed", 1, 8'he4, 8'h1b, 2'b01, 2'b01, 1);
    step("R6 w4 a8", 1, 8'hf9, 8'h83, 2'b10, 2'b11, 1);
    step("R6 w1 a4", 1, 8'h13, 8'h9a, 2'b00, 2'b10, 1);
    step("R5 w2 a1", 1, 8'hff, 8'hff, 2'b01, 2'b00, 0);
    step("R8 hold", 0, 8'h55, 8'haa, 2'b00, 2'b00, 0);
    step("R8 hold2", 0, 8'h12, 8'h34, 2'b11, 2'b11, 1);
    step("R7 after gap", 1, 8'h77, 8'h99, 2'b10, 2'b10, 1);
    for (int n = 0; n < 400; n++) begin
      logic v = ($urandom % 5) != 0;
      step(v ? "R7 R1 R2 R3 R5 random" : "R8 random idle", v,
           8'($urandom), 8'($urandom), 2'($urandom), 2'($urandom), 1'($urandom));
    end
    done = 1;
  end

  initial begin
    void'($urandom(32'd20240611));
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule